// File: doc/BRIEF.md
# Sequential GF(2^8) Inverter with a Two-Way Shift Register

This unit returns the multiplicative inverse of a byte in GF(2^8). It holds only one byte of state, an 8-bit shift register that can multiply its contents by x (forward step) or by x^-1 (backward step). It also has an 8-bit step counter. No tower-field arithmetic is used, and the unit holds no lookup table. The price of the small area is latency: every inversion takes 255 steps.

A start pulse loads the operand into the state register. The unit then steps forward, one step per clock, until the state equals the constant 0x01. If the operand is x^p, this match happens after 255-p steps. From that point the unit steps backward. It stops when forward and backward steps together reach 255, so the final state is x^-p. An operand of zero never reaches the constant. After 255 forward steps it comes out as zero, which matches the usual convention for substitution tables.

A build parameter selects the load path:
- **Parallel load** (default) writes all eight bits in one cycle.
- **Serial load** shifts the operand into stage 0 over eight extra cycles, MSB first. Only that stage then needs a load source. The end of loading is decoded from the step counter.

Top module: `lfsr_inverse_unit`

## Requirements
- R1: While reset is asserted, and until the first start, `done` is 0 and `result` is 0x00.
- R2: For every nonzero operand `a`, the result `r` satisfies a·r = 1 in GF(2^8) reduced by x^8+x^4+x^3+x^2+1 (0x11D).
- R3: Operand 0x00 gives result 0x00.
- R4: Operand 0x01, which equals the seed, gives result 0x01: zero forward steps and 255 backward steps.
- R5: In parallel-load mode, `done` rises exactly 255 clock cycles after the edge that samples `start`, for every operand.
- R6: `done` is high for exactly one cycle. `result` keeps its value from then until the next accepted start.
- R7: A `start` pulse that arrives while an inversion is running is ignored, together with the `din` value that comes with it. The running inversion still returns the inverse of its own operand.
- R8: In serial-load mode, `din` must be held for the eight load cycles. `done` then rises 263 cycles after the start edge, with the same result as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| start | input | 1 | Begin an inversion of `din` when the unit is idle |
| din | input | 8 | Operand byte |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 8 | Inverse of the last accepted operand |

## Verification
The assertions check the following on every clock:
- the step counter moves by exactly one per step;
- the backward phase never returns to forward;
- a seed match during the forward phase always switches the direction;
- a nonzero state never collapses to zero;
- a zero state stays zero;
- `done` never lasts two cycles.

Only the bench scenarios can show the rest. They cover the numerical correctness of the result for all 256 operands, the exact latency in both load variants, the holding of the result, and that a start pulse with a different operand in the middle of a run leaves the answer unchanged.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_FWD  = 2'd2,
    PH_REV  = 2'd3
  } phase_e;
endpackage

// File: rtl/gfinv_rst_sync.sv
module gfinv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/gfinv_seed_match.sv
module gfinv_seed_match #(
  parameter int            W    = 8,
  parameter logic [W-1:0]  SEED = 8'h01
) (
  input  logic [W-1:0] state,
  output logic         match
);
  logic [W-1:0] lit;

  // One literal per bit, then a single wide AND: no general comparator.
  for (genvar i = 0; i < W; i++) begin : g_lit
    if (SEED[i]) begin : g_one
      assign lit[i] = state[i];
    end else begin : g_zero
      assign lit[i] = ~state[i];
    end
  end

  assign match = &lit;
endmodule

// File: rtl/gfinv_lfsr.sv
module gfinv_lfsr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step_fwd,
  input  logic         step_rev,
  input  logic [W-1:0] load_v,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] POLY_DN = POLY >> 1;

  logic [W-1:0] state_q, state_d, fwd_v, rev_v;
  logic         en;

  // Galois form: forward = times x, backward = times x^-1.
  assign fwd_v = {state_q[W-2:0], 1'b0} ^ (state_q[W-1] ? POLY : '0);
  assign rev_v = state_q[0] ? ({1'b1, state_q[W-1:1]} ^ POLY_DN)
                            : {1'b0, state_q[W-1:1]};
  assign en    = load | step_fwd | step_rev;

  always_comb begin
    state_d = state_q;
    if (load)          state_d = load_v;
    else if (step_fwd) state_d = fwd_v;
    else if (step_rev) state_d = rev_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= '0;
    else if (en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: a nonzero element stays nonzero under either step
  assert_step_keeps_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != '0 && !load && (step_fwd || step_rev)) |=> state_q != '0);

  // R3: zero is a fixed point of both steps
  assert_zero_stays_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0 && !load && (step_fwd || step_rev)) |=> state_q == '0);
endmodule

// File: rtl/gfinv_ctrl.sv
module gfinv_ctrl
  import gfinv_pkg::*;
#(
  parameter int W      = 8,
  parameter bit SERIAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         match,
  output logic         load,
  output logic         step_fwd,
  output logic         step_rev,
  output logic         done,
  output logic [W-1:0] cnt
);
  localparam int           STEPS     = (1 << W) - 1;
  localparam logic [W-1:0] STEP_LAST = W'(STEPS - 1);
  localparam logic [W-1:0] LOAD_LAST = W'(W - 1);

  phase_e       phase_q, phase_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         done_q, done_d;
  logic         stepping;

  assign stepping = (phase_q == PH_FWD) || (phase_q == PH_REV);

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    load     = 1'b0;
    step_fwd = 1'b0;
    step_rev = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          load    = !SERIAL;
          phase_d = SERIAL ? PH_LOAD : PH_FWD;
          cnt_d   = '0;
        end
      end
      PH_LOAD: begin
        load = 1'b1;
        if (cnt_q == LOAD_LAST) begin
          phase_d = PH_FWD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + W'(1);
        end
      end
      default: begin
        if (phase_q == PH_FWD && !match) begin
          step_fwd = 1'b1;
        end else begin
          step_rev = 1'b1;
          phase_d  = PH_REV;
        end
        if (cnt_q == STEP_LAST) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;
  assign cnt  = cnt_q;

  // R5: each busy step advances the counter by exactly one
  assert_step_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && cnt_q != STEP_LAST) |=> cnt_q == $past(cnt_q) + W'(1));

  // R6: done never lasts more than one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a start during a run does not end or restart it
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && cnt_q != STEP_LAST && start) |=> stepping);

  // R2: seed reached while going forward switches to backward; never back again
  assert_match_turns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FWD && match && cnt_q != STEP_LAST) |=> phase_q == PH_REV);
  assert_rev_not_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_REV) |=> phase_q != PH_FWD);
endmodule

// File: rtl/lfsr_inverse_unit.sv
module lfsr_inverse_unit #(
  parameter int           W           = 8,
  parameter logic [W-1:0] POLY        = 8'h1D,
  parameter logic [W-1:0] SEED        = 8'h01,
  parameter bit           SERIAL_LOAD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] din,
  output logic         done,
  output logic [W-1:0] result
);
  logic         rst_i_n;
  logic [W-1:0] state, load_v, cnt;
  logic         load, step_fwd, step_rev, match;

  gfinv_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_i_n)
  );

  gfinv_ctrl #(.W(W), .SERIAL(SERIAL_LOAD)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .match    (match),
    .load     (load),
    .step_fwd (step_fwd),
    .step_rev (step_rev),
    .done     (done),
    .cnt      (cnt)
  );

  gfinv_seed_match #(.W(W), .SEED(SEED)) u_match (
    .state (state),
    .match (match)
  );

  if (SERIAL_LOAD) begin : g_serial
    logic [W-1:0] din_sh;
    // MSB first into stage 0; upper stages only shift.
    assign din_sh = din << cnt;
    assign load_v = {state[W-2:0], din_sh[W-1]};
  end else begin : g_parallel
    assign load_v = din;
    // R5: a parallel load only happens from idle, with the counter cleared
    assert_par_load_idle_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
      load |-> cnt == '0);
  end

  gfinv_lfsr #(.W(W), .POLY(POLY)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (load),
    .step_fwd (step_fwd),
    .step_rev (step_rev),
    .load_v   (load_v),
    .state_o  (state)
  );

  assign result = state;
endmodule

// File: tb/test_lfsr_inverse_unit.sv
module test_lfsr_inverse_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] din;
  logic       done_p, done_s;
  logic [7:0] res_p, res_s;

  always #10 clk = ~clk;

  lfsr_inverse_unit i_lfsr_inverse_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .done(done_p), .result(res_p)
  );

  lfsr_inverse_unit #(.SERIAL_LOAD(1'b1)) i_lfsr_inverse_unit_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .done(done_s), .result(res_s)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int rem_p, rem_s;
  logic ed_p, ed_s, have_p, have_s, poked;
  logic [7:0] val_p, val_s;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] inv_ref(input logic [7:0] a);
    if (a == 8'h00) return 8'h00;
    for (int b = 1; b < 256; b++)
      if (gf_mul(a, 8'(b)) == 8'h01) return 8'(b);
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [7:0] v, input logic pk);
    if (pk)         return "R7";
    if (v == 8'h00) return "R3";
    if (v == 8'h01) return "R4";
    return "R2";
  endfunction

  // Reference model: remaining cycles until done, per instance.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_p <= 0; rem_s <= 0; ed_p <= 1'b0; ed_s <= 1'b0;
      have_p <= 1'b0; have_s <= 1'b0;
    end else begin
      ed_p <= (rem_p == 1);
      ed_s <= (rem_s == 1);
      if (rem_p == 0 && start) begin rem_p <= 255; val_p <= din; have_p <= 1'b1; end
      else if (rem_p > 0) rem_p <= rem_p - 1;
      if (rem_s == 0 && start) begin rem_s <= 263; val_s <= din; have_s <= 1'b1; end
      else if (rem_s > 0) rem_s <= rem_s - 1;
    end
  end

  // Compare away from the active edge, every cycle.
  always @(negedge clk) begin
    if (!rst_n) begin
      checks += 1;
      if (done_p !== 1'b0 || res_p !== 8'h00 || done_s !== 1'b0 || res_s !== 8'h00) begin
        errors += 1;
        $display("FAIL R1 reset: done %b/%b result %h/%h expected 0/0 00/00",
                 done_p, done_s, res_p, res_s);
      end
    end else begin
      checks += 1;
      if (done_p !== ed_p) begin
        errors += 1;
        $display("FAIL R5/R6 parallel done: actual %b expected %b", done_p, ed_p);
      end
      checks += 1;
      if (done_s !== ed_s) begin
        errors += 1;
        $display("FAIL R8 serial done: actual %b expected %b", done_s, ed_s);
      end
      if (!have_p && !have_s) begin
        checks += 1;
        if (res_p !== 8'h00 || res_s !== 8'h00) begin
          errors += 1;
          $display("FAIL R1 idle after reset: result %h/%h expected 00", res_p, res_s);
        end
      end
      if (have_p && rem_p == 0) begin
        checks += 1;
        if (res_p !== inv_ref(val_p)) begin
          errors += 1;
          $display("FAIL %s/R6 parallel din %h: result %h expected %h",
                   tag_of(val_p, poked), val_p, res_p, inv_ref(val_p));
        end
      end
      if (have_s && rem_s == 0) begin
        checks += 1;
        if (res_s !== inv_ref(val_s)) begin
          errors += 1;
          $display("FAIL R8/%s serial din %h: result %h expected %h",
                   tag_of(val_s, poked), val_s, res_s, inv_ref(val_s));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc += 1;
    if (cyc > 150000) begin
      errors += 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [7:0] v, input logic poke);
    @(negedge clk);
    poked = poke;
    start = 1'b1;
    din   = v;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R7: start with another operand in mid-run (past serial loading)
      repeat (20) @(negedge clk);
      start = 1'b1;
      din   = ~v;
      @(negedge clk);
      start = 1'b0;
      din   = v;
    end
    while (rem_s != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    poked = 1'b0;
    start = 1'b0;
    din   = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R4 seed operand, R3 zero operand, then a few distinct patterns
    run(8'h01, 1'b0);
    run(8'h00, 1'b0);
    run(8'h02, 1'b0);
    run(8'h80, 1'b0);
    run(8'hFF, 1'b0);
    // R7 busy starts ignored
    run(8'h53, 1'b1);
    run(8'h00, 1'b1);
    // R2 exhaustive sweep over every operand
    for (int v = 0; v < 256; v++) run(8'(v), 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule